// File: doc/BRIEF.md
# Multi-Channel Contact Debouncer

This block removes the chatter from mechanical contacts such as relays and push buttons. It has six independent channels that share one sample clock. Each raw input first passes through a short synchronizer. The channel then compares the sampled level with its own clean output. While the two disagree, it records one "mismatch" mark per rising edge in a short history register. Any sample that agrees with the output wipes the whole history at once. The clean output takes the new level only on the edge that would add the fourth consecutive mark. The same rule applies to a contact that closes and to one that opens.

The inputs are meant for contacts that switch to ground. An open contact therefore reads high, and the idle clean output is also high. The channel count, history depth, synchronizer length and idle level are all parameters. The defaults are six channels, four marks and two synchronizer stages. With these defaults, a clean level change reaches the output exactly six rising edges after the first edge that samples it.

Top module: `contact_debouncer`

## Requirements
- R1: While a channel's synchronized sample differs from its clean output and the output has not yet flipped, each rising edge adds exactly one mark to that channel's history.
- R2: A single sample that agrees with the clean output clears all marks of that channel. Later differing samples count again from zero, so interrupted bounce never accumulates.
- R3: A raw level that stays stable for 6 rising edges, counted from the first edge that sees it, appears on the clean output at the 6th edge and not before. This is 2 synchronizer edges plus 4 marks.
- R4: The same 6-edge rule governs both a high-to-low and a low-to-high change of the output.
- R5: A synchronous active-high reset drives every clean output high and clears all history and synchronizer stages. A low raw input therefore needs 6 edges after reset to show.
- R6: On the edge where the output flips, that channel's history is cleared. An immediate change back needs another full 6 edges.
- R7: The six channels are independent: activity on one raw input never changes another channel's clean output.
- R8: A raw excursion seen by fewer than 4 sample edges never reaches the clean output.
- R9: A clean raw pulse held for W >= 4 edges produces a clean output pulse exactly W clock periods wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock shared by all channels |
| rst | input | 1 | Synchronous reset, active high |
| contact_raw | input | 6 | Raw contact levels, bit n belongs to channel n, high means open |
| contact_clean | output | 6 | Debounced levels, bit n belongs to channel n, high when idle |

## Verification
The assertions assume that the raw inputs only change away from the rising edge. They also assume that reset is held for at least one edge before any check counts on history. The bench drives every input change on the falling edge and starts with reset asserted, so each raw level is captured cleanly by the synchronizer. Expected outputs come from counting sample edges per level: fewer than four marks means no change, four means a flip. Reset is only released after a full edge has cleared the history.

// File: rtl/deb_pkg.sv
package deb_pkg;
   localparam int  DEB_CHANNELS    = 6;
   localparam int  DEB_MARKS       = 4;
   localparam int  DEB_SYNC_STAGES = 2;
   localparam bit  DEB_IDLE_LEVEL  = 1'b1;

   // edges from first sampling edge to output flip
   function automatic int deb_latency(input int sync_stages, input int marks);
      return sync_stages + marks;
   endfunction
endpackage

// File: rtl/deb_sync.sv
module deb_sync #(
   parameter int STAGES = 2,
   parameter bit IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 0) begin : g_bad_stages
      $error("deb_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else if (STAGES == 1) begin : g_single
      logic q1;
      always_ff @(posedge clk) begin
         if (rst) q1 <= IDLE;
         else     q1 <= d_i;
      end
      assign q_o = q1;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (rst) chain <= {STAGES{IDLE}};
         else     chain <= {chain[STAGES-2:0], d_i};
      end
      assign q_o = chain[STAGES-1];
   end
endmodule

// File: rtl/deb_channel.sv
module deb_channel #(
   parameter int MARKS       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit IDLE        = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_i,
   output logic clean_o
);
   localparam int HIST_W = MARKS - 1;

   if (MARKS < 2) begin : g_bad_marks
      $error("deb_channel: MARKS must be at least 2");
   end

   logic              samp;
   logic              clean_q;
   logic [HIST_W-1:0] hist;
   logic              differs;
   logic              full;

   deb_sync #(.STAGES(SYNC_STAGES), .IDLE(IDLE)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (raw_i),
      .q_o (samp)
   );

   assign differs = samp ^ clean_q;
   assign full    = &hist;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist    <= '0;
         clean_q <= IDLE;
      end else if (!differs) begin
         hist <= '0;
      end else if (full) begin
         clean_q <= samp;
         hist    <= '0;
      end else begin
         hist <= (hist << 1) | HIST_W'(1);
      end
   end

   assign clean_o = clean_q;

   AST_MARK_ADDED: assert property (@(posedge clk) disable iff (rst)
      (differs && !full) |=> ($countones(hist) == $countones($past(hist)) + 1)); // R1
   AST_AGREE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (!differs) |=> (hist == '0)); // R2
   AST_FLIP_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
      (clean_q != $past(clean_q)) |-> ($past(full) && $past(differs))); // R3
   AST_FLIP_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (clean_q != $past(clean_q)) |-> (hist == '0)); // R6
   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (clean_q == IDLE && hist == '0)); // R5
endmodule

// File: rtl/contact_debouncer.sv
module contact_debouncer
   import deb_pkg::*;
#(
   parameter int NUM_CH      = DEB_CHANNELS,
   parameter int MARKS       = DEB_MARKS,
   parameter int SYNC_STAGES = DEB_SYNC_STAGES,
   parameter bit IDLE        = DEB_IDLE_LEVEL
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] contact_raw,
   output logic [NUM_CH-1:0] contact_clean
);
   localparam int LATENCY = deb_latency(SYNC_STAGES, MARKS);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("contact_debouncer: NUM_CH must be at least 1");
   end
   if (LATENCY < 2) begin : g_bad_lat
      $error("contact_debouncer: latency too short");
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      deb_channel #(
         .MARKS       (MARKS),
         .SYNC_STAGES (SYNC_STAGES),
         .IDLE        (IDLE)
      ) u_chan (
         .clk     (clk),
         .rst     (rst),
         .raw_i   (contact_raw[ch]),
         .clean_o (contact_clean[ch])
      );
   end

   AST_ALL_IDLE_AFTER_RESET: assert property (@(posedge clk)
      rst |=> (contact_clean == {NUM_CH{IDLE}})); // R5
endmodule

// File: tb/contact_debouncer_tb.sv
`timescale 1ns/1ps
module contact_debouncer_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] raw = 6'h3F;
   logic [5:0] clean;
   int         total = 0;
   int         bad   = 0;
   bit         done  = 1'b0;

   always #4 clk = ~clk;

   contact_debouncer u_dut (
      .clk           (clk),
      .rst           (rst),
      .contact_raw   (raw),
      .contact_clean (clean)
   );

   // {raw level, edges held, expected clean after those edges}
   localparam int NVEC = 18;
   localparam logic [19:0] VEC [NVEC] = '{
      {6'h3F, 8'd8, 6'h3F},   // R5 idle high
      {6'h3E, 8'd3, 6'h3F},   // R8 three-edge glitch
      {6'h3F, 8'd8, 6'h3F},   // R8 / R2 no trace
      {6'h3E, 8'd5, 6'h3F},   // R3 not yet at edge 5
      {6'h3E, 8'd1, 6'h3E},   // R3 flips at edge 6
      {6'h3F, 8'd5, 6'h3E},   // R4 release not yet
      {6'h3F, 8'd1, 6'h3F},   // R4 release at edge 6
      {6'h3E, 8'd2, 6'h3F},   // R2 bounce
      {6'h3F, 8'd1, 6'h3F},   // R2 agree clears
      {6'h3E, 8'd2, 6'h3F},   // R2 bounce
      {6'h3F, 8'd1, 6'h3F},   // R2 agree clears
      {6'h3E, 8'd3, 6'h3F},   // R2 marks restart
      {6'h3E, 8'd3, 6'h3E},   // R2 settles
      {6'h3F, 8'd6, 6'h3F},   // R4
      {6'h00, 8'd6, 6'h00},   // R7 all channels
      {6'h2A, 8'd6, 6'h2A},   // R4 mixed directions
      {6'h15, 8'd6, 6'h15},   // R7 mixed
      {6'h3F, 8'd6, 6'h3F}    // R4
   };

   task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R3 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int lowcnt;
      @(negedge clk);
      edges(2);
      chk("R5", clean, 6'h3F);
      rst = 1'b0;

      for (int i = 0; i < NVEC; i++) begin
         raw = VEC[i][19:14];
         edges(int'(VEC[i][13:6]));
         chk($sformatf("R3 vec%0d", i), clean, VEC[i][5:0]);
      end

      // R6: flip then immediate reversal needs a full fresh window
      raw = 6'h3D;
      edges(6);
      chk("R6", clean, 6'h3D);
      raw = 6'h3F;
      edges(5);
      chk("R6", clean, 6'h3D);
      edges(1);
      chk("R6", clean, 6'h3F);

      // R9 pulse width and R7 independence under bounce
      lowcnt = 0;
      raw = 6'h3B;
      for (int k = 0; k < 7; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (!clean[2]) lowcnt++;
      end
      raw = 6'h3F;
      for (int k = 0; k < 14; k++) begin
         raw[3] = (k % 2 == 0);
         @(posedge clk);
         @(negedge clk);
         if (!clean[2]) lowcnt++;
         chk("R7", {clean[5:4], clean[3], clean[1:0]}, 5'h1F);
      end
      raw = 6'h3F;
      chk("R9", 6'(lowcnt), 6'd7);
      edges(8);
      chk("R8", clean, 6'h3F);

      // R5: reset mid-activity
      raw = 6'h00;
      edges(6);
      chk("R3", clean, 6'h00);
      rst = 1'b1;
      edges(1);
      chk("R5", clean, 6'h3F);
      edges(1);
      rst = 1'b0;
      edges(5);
      chk("R5", clean, 6'h3F);
      edges(1);
      chk("R5", clean, 6'h00);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule